// File: doc/BRIEF.md
# Multi-Source Maskable Interrupt Controller

This block gathers interrupt requests from four kinds of source and gives the core one prioritized answer. The sources are six external request lines that are level-sensitive, three internal event inputs that are edge-detected and latched, a request register that software writes, and four asynchronous trap requests, one per processor mode. A trap request counts only while the current processor mode is at least as privileged as the trap's mode. Every source has its own enable bit in a mask register.

All sources share one pending vector, and a bit's position in it is its priority. Bits [3:0] hold the traps, with trap m at bit m. Bits [7:4] hold software request s at bit 4+s. Bits [10:8] hold edge event e at bit 8+e. Bits [16:11] hold level line l at bit 11+l. The highest set bit wins. Level lines therefore beat edge events, edge events beat software requests, and software requests beat traps. Within a class, the higher index wins. A single register write port programs the mask, sets the software requests and clears latched edge events. The request line and the encoded winner are registered once.

Top module: `irq_ctrl`

## Requirements
- R1: A level line l drives pending bit 11+l combinationally, ANDed with its mask bit, with no latch. Dropping the line drops the bit in the same cycle.
- R2: A rising edge on event input e (prev 0, now 1 at a clock edge) sets latch e, which shows at pending bit 8+e after that edge. The latch stays set until a write to address 2 with data bit e set clears it. If a clear and a new rising edge meet in the same cycle, the latch is set.
- R3: A write to address 1 loads data bits [3:0] into the software request register. Bit s drives pending bit 4+s in the cycle after the write.
- R4: Trap request m drives pending bit m only while cur_mode_i <= m, where mode 0 is the most privileged and mode 3 the least.
- R5: A write to address 0 loads data bits [16:0] into the mask. Mask bit k set to 1 enables pending bit k from the cycle after the write. The mask does not block edge capture: an event latched while masked appears once it is unmasked.
- R6: irq_o equals the OR of all bits of pending_o in the previous cycle.
- R7: irq_id_o holds, in the same cycle as irq_o, the index of the highest set bit of the previous cycle's pending_o. It is 0 when no bit was set.
- R8: While rst_ni is low, the mask, the software requests and the edge latches are cleared, and pending_o, irq_o and irq_id_o are all 0.
- R9: A write to address 3 changes no state, so pending_o, irq_o and irq_id_o continue as if no write had happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| lvl_irq_i | input | 6 | Level-sensitive external request lines |
| evt_i | input | 3 | Edge-detected internal event inputs (synchronous) |
| ast_req_i | input | 4 | Asynchronous trap request, one per processor mode |
| cur_mode_i | input | 2 | Current processor mode, 0 most privileged |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 mask, 1 software request, 2 edge clear, 3 spare |
| wr_data_i | input | 32 | Register write data |
| pending_o | output | 17 | Masked and qualified pending vector |
| irq_o | output | 1 | Interrupt request, registered |
| irq_id_o | output | 5 | Index of highest-priority pending bit, registered |

## Verification
pending_o is due in the same cycle as a change on a level line, a trap request or the mode. It is due one edge later after a register write or an event's rising edge, because those pass through a register first. irq_o and irq_id_o are due one edge after the pending vector they summarize. The bench drives all inputs on the falling edge and keeps a model of the registers that it advances at each rising edge. From that model it works out the pending vector the design should show, and it keeps the previous cycle's OR and top index as the expected registered outputs. All three outputs are compared at the next falling edge, so each result is read in the cycle it is due.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared types for the interrupt controller.
// Assumes a two-bit register address space.
package irq_ctrl_pkg;

    // Register addresses decoded by the write port
    typedef enum logic [1:0] {
        REG_MASK    = 2'd0,
        REG_SWREQ   = 2'd1,
        REG_EDGECLR = 2'd2,
        REG_SPARE   = 2'd3
    } irq_reg_e;

endpackage

// File: rtl/irq_edge_latch.sv
// Module: per-bit rising-edge detector with sticky latch.
// Holds each event until a write-one-to-clear bit arrives; a new edge
// in the same cycle as its clear wins. Inputs are assumed synchronous.
module irq_edge_latch #(
    parameter int N_EVT = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_EVT-1:0] evt_i,
    input  logic [N_EVT-1:0] clr_i,
    output logic [N_EVT-1:0] lat_o
);

    logic [N_EVT-1:0] prev_q;

    for (genvar e = 0; e < N_EVT; e++) begin : g_evt
        // Remember the last sampled level of event e
        always_ff @(posedge clk_i) begin
            if (!rst_ni) prev_q[e] <= 1'b0;
            else         prev_q[e] <= evt_i[e];
        end

        // Set on rising edge, clear on request, set dominates
        always_ff @(posedge clk_i) begin
            if (!rst_ni)                     lat_o[e] <= 1'b0;
            else if (evt_i[e] && !prev_q[e]) lat_o[e] <= 1'b1;
            else if (clr_i[e])               lat_o[e] <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_mode_gate.sv
// Module: qualifies per-mode trap requests by the current processor mode.
// Assumes mode 0 is the most privileged; trap m passes when mode <= m.
module irq_mode_gate #(
    parameter int N_MODE = 4,
    localparam int MODE_W = (N_MODE > 1) ? $clog2(N_MODE) : 1
) (
    input  logic [N_MODE-1:0] req_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic [N_MODE-1:0] qual_o
);

    for (genvar m = 0; m < N_MODE; m++) begin : g_mode
        // Trap m is live only at equal or higher privilege
        assign qual_o[m] = req_i[m] && (mode_i <= MODE_W'(m));
    end

endmodule

// File: rtl/irq_prio_enc.sv
// Module: highest-set-bit encoder.
// Assumes priority rises with bit index; outputs 0 when nothing is set.
module irq_prio_enc #(
    parameter int N = 17,
    localparam int ID_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    vec_i,
    output logic            any_o,
    output logic [ID_W-1:0] id_o
);

    // Scan upward so the last hit, the highest index, is kept
    always_comb begin
        id_o = '0;
        for (int i = 0; i < N; i++) begin
            if (vec_i[i]) id_o = ID_W'(i);
        end
    end

    // Flag any request at all
    assign any_o = |vec_i;

endmodule

// File: rtl/irq_ctrl.sv
// Module: top of the multi-source maskable interrupt controller.
// Builds the pending vector {level, edge, software, trap} (high to low),
// masks it, and registers the request line and winning index.
// Assumes a synchronous active-low reset and synchronous inputs.
module irq_ctrl #(
    parameter int N_LVL  = 6,
    parameter int N_EDGE = 3,
    parameter int N_SW   = 4,
    parameter int N_MODE = 4,
    parameter int DATA_W = 32,
    localparam int N_SRC   = N_LVL + N_EDGE + N_SW + N_MODE,
    localparam int ID_W    = $clog2(N_SRC),
    localparam int MODE_W  = (N_MODE > 1) ? $clog2(N_MODE) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_LVL-1:0]  lvl_irq_i,
    input  logic [N_EDGE-1:0] evt_i,
    input  logic [N_MODE-1:0] ast_req_i,
    input  logic [MODE_W-1:0] cur_mode_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [N_SRC-1:0]  pending_o,
    output logic              irq_o,
    output logic [ID_W-1:0]   irq_id_o
);
    import irq_ctrl_pkg::*;

    localparam int SW_LO   = N_MODE;
    localparam int EDGE_LO = SW_LO + N_SW;
    localparam int LVL_LO  = EDGE_LO + N_EDGE;

    logic [N_SRC-1:0]  mask_q;
    logic [N_SW-1:0]   sw_q;
    logic [N_EDGE-1:0] edge_q;
    logic [N_EDGE-1:0] edge_clr;
    logic [N_MODE-1:0] trap_qual;
    logic [N_SRC-1:0]  raw_vec;
    logic              any_pend;
    logic [ID_W-1:0]   top_id;
    logic              unused_wdata;
    irq_reg_e          wr_reg;

    assign wr_reg       = irq_reg_e'(wr_addr_i);
    assign unused_wdata = ^wr_data_i;

    // Mask register load
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                            mask_q <= '0;
        else if (wr_en_i && wr_reg == REG_MASK) mask_q <= wr_data_i[N_SRC-1:0];
    end

    // Software request register load
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                             sw_q <= '0;
        else if (wr_en_i && wr_reg == REG_SWREQ) sw_q <= wr_data_i[N_SW-1:0];
    end

    // Write-one-to-clear strobe for the edge latches
    assign edge_clr = (wr_en_i && wr_reg == REG_EDGECLR) ? wr_data_i[N_EDGE-1:0]
                                                         : '0;

    irq_edge_latch #(.N_EVT(N_EDGE)) edge_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .evt_i  (evt_i),
        .clr_i  (edge_clr),
        .lat_o  (edge_q)
    );

    irq_mode_gate #(.N_MODE(N_MODE)) gate_i (
        .req_i  (ast_req_i),
        .mode_i (cur_mode_i),
        .qual_o (trap_qual)
    );

    // Assemble unmasked vector; position equals priority
    assign raw_vec[SW_LO-1:0]      = trap_qual;
    assign raw_vec[EDGE_LO-1:SW_LO] = sw_q;
    assign raw_vec[LVL_LO-1:EDGE_LO] = edge_q;
    assign raw_vec[N_SRC-1:LVL_LO] = lvl_irq_i;

    // Apply per-source enables
    assign pending_o = raw_vec & mask_q;

    irq_prio_enc #(.N(N_SRC)) enc_i (
        .vec_i (pending_o),
        .any_o (any_pend),
        .id_o  (top_id)
    );

    // Register request line and winner together
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            irq_o    <= 1'b0;
            irq_id_o <= '0;
        end else begin
            irq_o    <= any_pend;
            irq_id_o <= top_id;
        end
    end

endmodule

// File: rtl/irq_ctrl_chk.sv
// Module: property checker for irq_ctrl, attached by bind below.
// Watches ports plus the mask and edge latch state of the top.
module irq_ctrl_chk #(
    parameter int N_SRC  = 17,
    parameter int N_EDGE = 3,
    parameter int N_MODE = 4,
    parameter int ID_W   = 5,
    parameter int MODE_W = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [N_SRC-1:0]  pending_o,
    input logic              irq_o,
    input logic [ID_W-1:0]   irq_id_o,
    input logic [N_SRC-1:0]  mask_q,
    input logic [N_EDGE-1:0] edge_q,
    input logic [MODE_W-1:0] cur_mode_i,
    input logic              wr_en_i,
    input logic [1:0]        wr_addr_i
);

    // R6
    irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == $past(|pending_o));

    // R7
    id_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (($past(pending_o) >> irq_id_o) == 1));

    // R7
    id_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_o |-> (irq_id_o == '0));

    // R5
    mask_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pending_o & ~mask_q) == '0);

    // R4
    trap_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pending_o[N_MODE-1:0] & N_MODE'((1 << cur_mode_i) - 1)) == '0);

    // R2
    edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && wr_addr_i == 2'd2) |=> ((edge_q & $past(edge_q)) == $past(edge_q)));

endmodule

bind irq_ctrl irq_ctrl_chk #(
    .N_SRC  (N_SRC),
    .N_EDGE (N_EDGE),
    .N_MODE (N_MODE),
    .ID_W   (ID_W),
    .MODE_W (MODE_W)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pending_o  (pending_o),
    .irq_o      (irq_o),
    .irq_id_o   (irq_id_o),
    .mask_q     (mask_q),
    .edge_q     (edge_q),
    .cur_mode_i (cur_mode_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i)
);

// File: tb/irq_ctrl_tb_top.sv
// Bench: sweeps over each source class plus a pseudo-random mixed phase,
// checked against a register model advanced at every rising edge.
module irq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  lvl = '0;
    logic [2:0]  evt = '0;
    logic [3:0]  ast = '0;
    logic [1:0]  mode = '0;
    logic        we = 1'b0;
    logic [1:0]  wa = '0;
    logic [31:0] wd = '0;
    logic [16:0] pend;
    logic        irq;
    logic [4:0]  id;

    // model state
    logic [16:0] m_mask = '0;
    logic [3:0]  m_sw = '0;
    logic [2:0]  m_lat = '0;
    logic [2:0]  m_prev = '0;
    logic        m_irq = 1'b0;
    logic [4:0]  m_id = '0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ctrl dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .lvl_irq_i  (lvl),
        .evt_i      (evt),
        .ast_req_i  (ast),
        .cur_mode_i (mode),
        .wr_en_i    (we),
        .wr_addr_i  (wa),
        .wr_data_i  (wd),
        .pending_o  (pend),
        .irq_o      (irq),
        .irq_id_o   (id)
    );

    function automatic logic [16:0] pend_f();
        logic [16:0] p = '0;
        for (int m = 0; m < 4; m++) p[m] = ast[m] && (int'(mode) <= m);
        p[7:4]   = m_sw;
        p[10:8]  = m_lat;
        p[16:11] = lvl;
        return p & m_mask;
    endfunction

    function automatic logic [4:0] hi_f(logic [16:0] p);
        logic [4:0] r = '0;
        for (int i = 0; i < 17; i++) if (p[i]) r = 5'(i);
        return r;
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " pending"}, int'(pend), int'(pend_f()));
        chk({tag, " irq"},     int'(irq),  int'(m_irq));
        chk({tag, " id"},      int'(id),   int'(m_id));
    endtask

    // one clock: advance model at posedge, compare at negedge
    task automatic tick(string tag);
        logic [16:0] p = pend_f();
        logic [2:0]  rise = evt & ~m_prev;
        logic [2:0]  clr = (we && wa == 2'd2) ? wd[2:0] : 3'b0;
        @(posedge clk);
        m_lat  = (m_lat & ~clr) | rise;
        m_prev = evt;
        if (we && wa == 2'd0) m_mask = wd[16:0];
        if (we && wa == 2'd1) m_sw = wd[3:0];
        m_irq = |p;
        m_id  = hi_f(p);
        @(negedge clk);
        we = 1'b0;
        check_all(tag);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d, string tag);
        we = 1'b1; wa = a; wd = d;
        tick(tag);
    endtask

    initial begin
        logic [31:0] s = 32'h1234_5678;
        // R8: reset state
        mode = 2'd3; ast = 4'hF; lvl = 6'h3F;
        repeat (3) @(negedge clk);
        check_all("R8 reset");
        @(negedge clk);
        rst_n = 1'b1;
        tick("R8 after reset, mask clear");

        // R1: level sweep with everything enabled
        lvl = '0; ast = '0; mode = '0;
        wr(2'd0, 32'h1FFFF, "R5 mask all");
        for (int v = 0; v < 64; v++) begin
            lvl = 6'(v);
            tick("R1 level sweep");
        end
        lvl = '0;
        tick("R1 level drop");

        // R5: mask sweep over level bits
        lvl = 6'h3F;
        for (int v = 0; v < 64; v++) wr(2'd0, 32'(v) << 11, "R5 mask sweep");
        lvl = '0;
        wr(2'd0, 32'h1FFFF, "R5 mask all");

        // R3: software request sweep
        for (int v = 0; v < 16; v++) wr(2'd1, 32'(v), "R3 sw sweep");
        wr(2'd1, 32'h0, "R3 sw clear");

        // R4: trap x mode sweep
        for (int v = 0; v < 64; v++) begin
            ast = 4'(v); mode = 2'(v >> 4);
            tick("R4 trap mode sweep");
        end
        ast = '0; mode = '0;

        // R2: edge capture, hold, clear, collision, masked capture
        evt = 3'b101; tick("R2 rise");
        evt = 3'b000; tick("R2 hold");
        tick("R2 hold");
        evt = 3'b111; tick("R2 rise other");
        tick("R2 level held no new edge");
        wr(2'd2, 32'h1, "R2 clear bit0 while high");
        evt = 3'b000; tick("R2 fall");
        evt = 3'b010; wr(2'd2, 32'h2, "R2 set beats clear");
        tick("R2 still set");
        evt = 3'b000; wr(2'd2, 32'h7, "R2 clear all");
        wr(2'd0, 32'h0, "R5 mask off");
        evt = 3'b100; tick("R5 masked capture");
        evt = 3'b000; tick("R5 masked hidden");
        wr(2'd0, 32'h1FFFF, "R5 unmask shows latched");
        tick("R2 latched visible");

        // R9: spare address ignored
        wr(2'd1, 32'h5, "R3 sw set");
        wr(2'd3, 32'hFFFF_FFFF, "R9 spare write");
        tick("R9 after spare");

        // R7: mixed pseudo-random traffic
        for (int k = 0; k < 300; k++) begin
            s ^= s << 13; s ^= s >> 17; s ^= s << 5;
            lvl  = s[5:0] & s[11:6] & s[17:12];
            evt  = s[20:18];
            ast  = s[24:21];
            mode = s[26:25];
            if (s[29:27] == 3'd0) begin
                we = 1'b1; wa = s[31:30]; wd = {s[15:0], s[31:16]};
            end
            tick("R7 mixed priority");
        end

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule